// File: doc/BRIEF.md
# Configurable UART with Error Detection

This block is a full-duplex asynchronous serial port. It has one transmit line and one receive line, and both idle high. Software configures it through a small byte-wide register file. The frame format covers a data length of 1 to 8 bits, none, even or odd parity, and one or two stop bits. The bit rate comes from a 16-bit divisor that is written as a high byte and a low byte. Software loads characters into a one-entry transmit buffer, and collects received characters from a one-entry receive buffer.

The receiver resynchronises on every start edge and samples each bit near its centre, using a tick at eight times the bit rate. It keeps four sticky error flags: parity, overrun, framing and break. The transmitter and the receiver each have their own enable bit and their own interrupt-enable bit. A run bit acts as a software reset. While the run bit is 0, the serial logic is held idle and all flags are cleared. Software sets the run bit to 1 after configuration to start operation.

Register map (3-bit address):
- 0 is the format register: [2:0] data length minus one, [4:3] parity, [5] two stop bits.
- 1 is the divisor high byte and 2 is the divisor low byte.
- 3 is the control register: [0] transmit enable, [1] receive enable, [2] transmit interrupt enable, [3] receive interrupt enable, [4] run.
- 4 is the status register (read only).
- 5 is the transmit buffer (write only).
- 6 is the receive buffer (read only).

Top module: `uart_core`

## Requirements
- R1: A transmitted frame is one low start bit, then the data bits least-significant first, then the optional parity bit, then the stop bits driven high. The line is high whenever no frame is being sent.
- R2: The data length is format[2:0]+1 bits, from 1 to 8. A received character appears in the receive buffer right-justified, with its unused upper bits reading 0.
- R3: The parity mode is set by format[4:3]: 00 selects none, 01 even (the count of ones over data and parity bit is even), 10 odd, and 11 none.
- R4: format[5]=1 sends two stop bits and expects two stop bits on receive. format[5]=0 uses one stop bit.
- R5: Every bit lasts exactly (divisor+1)*8 clock cycles. With a divisor of 78 this is 632 cycles, which gives about 4800 baud from a 3 MHz clock.
- R6: Status[0] (transmit ready) goes to 0 when the transmit buffer is written. It returns to 1 when the character moves to the shifter. The transmit interrupt is high while run, transmit enable, transmit interrupt enable and transmit ready are all 1.
- R7: Status[2] (receive ready) goes to 1 when a character completes, and goes to 0 when the receive buffer is read. The receive interrupt is high while run and receive interrupt enable are 1 and either receive ready or break is 1.
- R8: Status[3] is set when the received parity bit is wrong. Status[5] is set when a stop bit is sampled low. In both cases the character is still delivered.
- R9: Status[4] (overrun) is set when a character completes while receive ready is still 1. The newer character replaces the older one.
- R10: Status[6] (break) is set when the line stays low from the start bit through the last stop bit. No character is delivered for such a frame.
- R11: A low pulse on the receive line that is high again at the centre of the start bit is ignored.
- R12: When transmit enable is 0, a buffered character is not sent and the line stays high. When receive enable is 0, incoming frames are ignored.
- R13: While control[4] (run) is 0, the line is high, the status register reads 0x03 and both interrupts are low. After reset, status reads 0x03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on the receive buffer) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit-ready interrupt |
| rx_irq | output | 1 | Receive-ready or break interrupt |

## Verification
The receive error paths are the hardest to reach from the ports. A looped-back transmitter only ever produces well-formed frames, so it cannot trigger them. The bench therefore switches the receive line over to its own bit driver. That driver builds frames with a flipped parity bit or a low stop bit, holds the line low for a whole frame to produce a break, and sends glitches shorter than half a bit. Overrun is produced by sending two frames back to back without reading the buffer. The format sweep instead loops the transmitter into the receiver across all 64 combinations of length, parity and stop bits.

// File: rtl/uart_pkg.sv
package uart_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 3;
    localparam int LEN_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] A_FMT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIVH = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIVL = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXB  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RXB  = 3'd6;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic             stop2;
        par_mode_e        par;
        logic [LEN_W-1:0] len_m1;
    } frame_cfg_t;

    typedef struct packed {
        logic run;
        logic rx_ie;
        logic tx_ie;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic brk;
        logic frm;
        logic ovr;
        logic par;
    } rx_err_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT
    } rx_state_e;

    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len_m1);
        return {DATA_W{1'b1}} >> (LEN_W'(DATA_W - 1) - len_m1);
    endfunction

    function automatic logic par_on(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        logic p;
        p = ^(d & len_mask(c.len_m1));
        return (c.par == PAR_ODD) ? ~p : p;
    endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || cnt == '0) begin
            cnt <= div;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = !rst && !restart && (cnt == '0);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              full,
    input  frame_cfg_t        cfg,
    input  logic [DATA_W-1:0] din,
    output logic              load,
    output logic              idle,
    output logic              txd
);
    tx_state_e         st;
    logic [2:0]        ph;
    logic [LEN_W-1:0]  bi;
    logic              si;
    logic              pb;
    logic [DATA_W-1:0] sh;

    assign load = (st == TX_IDLE) && en && full;
    assign idle = (st == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= TX_IDLE;
            txd <= 1'b1;
            ph  <= '0;
            bi  <= '0;
            si  <= 1'b0;
            pb  <= 1'b0;
            sh  <= '0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (load) begin
                        st  <= TX_START;
                        txd <= 1'b0;
                        sh  <= din;
                        pb  <= par_bit(din, cfg);
                        ph  <= 3'd7;
                    end
                end
                default: begin
                    if (tick) begin
                        if (ph != 3'd0) begin
                            ph <= ph - 1'b1;
                        end else begin
                            ph <= 3'd7;
                            case (st)
                                TX_START: begin
                                    st  <= TX_DATA;
                                    txd <= sh[0];
                                    sh  <= sh >> 1;
                                    bi  <= '0;
                                end
                                TX_DATA: begin
                                    if (bi == cfg.len_m1) begin
                                        si <= 1'b0;
                                        if (par_on(cfg.par)) begin
                                            st  <= TX_PAR;
                                            txd <= pb;
                                        end else begin
                                            st  <= TX_STOP;
                                            txd <= 1'b1;
                                        end
                                    end else begin
                                        bi  <= bi + 1'b1;
                                        txd <= sh[0];
                                        sh  <= sh >> 1;
                                    end
                                end
                                TX_PAR: begin
                                    st  <= TX_STOP;
                                    txd <= 1'b1;
                                end
                                TX_STOP: begin
                                    if (cfg.stop2 && !si) si <= 1'b1;
                                    else                  st <= TX_IDLE;
                                end
                                default: st <= TX_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  frame_cfg_t        cfg,
    output logic              restart,
    output logic              done,
    output logic              perr,
    output logic              ferr,
    output logic              brk,
    output logic [DATA_W-1:0] data
);
    rx_state_e         st;
    logic [2:0]        ph;
    logic [LEN_W-1:0]  bi;
    logic              si, zero, pacc, pbad, fbad;
    logic [DATA_W-1:0] sh;
    logic              low_seen, brk_now, exp_par;

    assign restart  = (st == RX_IDLE) && en && !rxd;
    assign low_seen = fbad || !rxd;
    assign brk_now  = zero && !rxd;
    assign exp_par  = (cfg.par == PAR_ODD) ? ~pacc : pacc;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        perr <= 1'b0;
        ferr <= 1'b0;
        brk  <= 1'b0;
        if (rst) begin
            st   <= RX_IDLE;
            ph   <= '0;
            bi   <= '0;
            si   <= 1'b0;
            zero <= 1'b0;
            pacc <= 1'b0;
            pbad <= 1'b0;
            fbad <= 1'b0;
            sh   <= '0;
            data <= '0;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (restart) begin
                        st <= RX_START;
                        ph <= 3'd3;
                    end
                end
                RX_WAIT: begin
                    if (rxd) st <= RX_IDLE;
                end
                default: begin
                    if (tick) begin
                        if (ph != 3'd0) begin
                            ph <= ph - 1'b1;
                        end else begin
                            ph <= 3'd7;
                            case (st)
                                RX_START: begin
                                    if (rxd) begin
                                        st <= RX_IDLE;
                                    end else begin
                                        st   <= RX_DATA;
                                        bi   <= '0;
                                        zero <= 1'b1;
                                        pacc <= 1'b0;
                                        pbad <= 1'b0;
                                        fbad <= 1'b0;
                                        sh   <= '0;
                                    end
                                end
                                RX_DATA: begin
                                    sh   <= {rxd, sh[DATA_W-1:1]};
                                    pacc <= pacc ^ rxd;
                                    zero <= zero & !rxd;
                                    if (bi == cfg.len_m1) begin
                                        si <= 1'b0;
                                        st <= par_on(cfg.par) ? RX_PAR : RX_STOP;
                                    end else begin
                                        bi <= bi + 1'b1;
                                    end
                                end
                                RX_PAR: begin
                                    pbad <= (rxd != exp_par);
                                    zero <= zero & !rxd;
                                    st   <= RX_STOP;
                                end
                                RX_STOP: begin
                                    if (cfg.stop2 && !si) begin
                                        si   <= 1'b1;
                                        fbad <= low_seen;
                                        zero <= zero & !rxd;
                                    end else begin
                                        st   <= RX_WAIT;
                                        data <= sh >> (LEN_W'(DATA_W - 1) - cfg.len_m1);
                                        done <= !brk_now;
                                        perr <= !brk_now && pbad;
                                        ferr <= !brk_now && low_seen;
                                        brk  <= brk_now;
                                    end
                                end
                                default: st <= RX_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_core.sv
module uart_core
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_irq,
    output logic              rx_irq
);
    frame_cfg_t        cfg_q;
    logic [DIV_W-1:0]  div_q;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] tx_buf, rx_buf, rx_data;
    logic              tx_full, rx_ready;
    rx_err_t           err_q;
    logic              soft_rst, tx_ready, tx_idle_s, tx_load;
    logic              tx_tick, rx_tick, rx_restart;
    logic              rx_done, rx_perr, rx_ferr, rx_brk;
    logic [1:0]        rx_sync;
    logic              wr_txb, rd_rxb;

    assign soft_rst = rst || !ctrl_q.run;
    assign wr_txb   = wr_en && (addr == A_TXB);
    assign rd_rxb   = rd_en && (addr == A_RXB);
    assign tx_ready = !tx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= frame_cfg_t'(6'b000111);
            div_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_FMT:   cfg_q  <= frame_cfg_t'(wdata[5:0]);
                A_DIVH:  div_q[DIV_W-1:DATA_W] <= wdata;
                A_DIVL:  div_q[DATA_W-1:0]     <= wdata;
                A_CTRL:  ctrl_q <= ctrl_t'(wdata[4:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rx_sync <= 2'b11;
        else     rx_sync <= {rx_sync[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            tx_full  <= 1'b0;
            tx_buf   <= '0;
            rx_ready <= 1'b0;
            rx_buf   <= '0;
            err_q    <= '0;
        end else begin
            if (wr_txb) begin
                tx_full <= 1'b1;
                tx_buf  <= wdata;
            end else if (tx_load) begin
                tx_full <= 1'b0;
            end
            if (rx_done) begin
                rx_ready <= 1'b1;
                rx_buf   <= rx_data;
            end else if (rd_rxb) begin
                rx_ready <= 1'b0;
            end
            err_q.par <= err_q.par | rx_perr;
            err_q.frm <= err_q.frm | rx_ferr;
            err_q.brk <= err_q.brk | rx_brk;
            err_q.ovr <= err_q.ovr | (rx_done && rx_ready);
        end
    end

    uart_baud #(.DIV_W(DIV_W)) i_tx_baud (
        .clk(clk), .rst(soft_rst), .restart(tx_load), .div(div_q), .tick(tx_tick)
    );

    uart_baud #(.DIV_W(DIV_W)) i_rx_baud (
        .clk(clk), .rst(soft_rst), .restart(rx_restart), .div(div_q), .tick(rx_tick)
    );

    uart_tx i_tx (
        .clk(clk), .rst(soft_rst), .en(ctrl_q.tx_en), .tick(tx_tick),
        .full(tx_full), .cfg(cfg_q), .din(tx_buf),
        .load(tx_load), .idle(tx_idle_s), .txd(txd)
    );

    uart_rx i_rx (
        .clk(clk), .rst(soft_rst), .en(ctrl_q.rx_en), .tick(rx_tick),
        .rxd(rx_sync[1]), .cfg(cfg_q), .restart(rx_restart),
        .done(rx_done), .perr(rx_perr), .ferr(rx_ferr), .brk(rx_brk), .data(rx_data)
    );

    assign tx_irq = ctrl_q.run && ctrl_q.tx_en && ctrl_q.tx_ie && tx_ready;
    assign rx_irq = ctrl_q.run && ctrl_q.rx_ie && (rx_ready || err_q.brk);

    always_comb begin
        case (addr)
            A_FMT:   rdata = {2'b00, cfg_q};
            A_DIVH:  rdata = div_q[DIV_W-1:DATA_W];
            A_DIVL:  rdata = div_q[DATA_W-1:0];
            A_CTRL:  rdata = {3'b000, ctrl_q};
            A_STAT:  rdata = {1'b0, err_q, rx_ready, tx_idle_s && !tx_full, tx_ready};
            A_RXB:   rdata = rx_buf;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk
    import uart_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              txd,
    input logic              tx_irq,
    input logic              rx_irq,
    input logic              tx_full,
    input logic              rx_ready,
    input logic              rx_done,
    input logic [3:0]        err_bits
);
    assert_line_high_R13: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> txd);

    assert_flags_clear_R13: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (err_bits == 4'd0 && !rx_ready));

    assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (!tx_irq && !rx_irq));

    assert_txbuf_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && wr_en && addr == A_TXB) |=> tx_full);

    assert_rxbuf_read_R7: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && rd_en && addr == A_RXB && !rx_done) |=> !rx_ready);

    assert_done_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && rx_done) |=> rx_ready);

    assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && rx_done && rx_ready) |=> err_bits[1]);
endmodule

bind uart_core uart_core_chk i_chk (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_full(tx_full),
    .rx_ready(rx_ready), .rx_done(rx_done), .err_bits(err_q)
);

// File: tb/test_uart_core.sv
module test_uart_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd, tx_irq, rx_irq;
    logic       loop = 1'b1;
    logic       rx_drv = 1'b1;
    logic       rxd;
    int         checks = 0, errors = 0;

    assign rxd = loop ? txd : rx_drv;

    always #5 clk = ~clk;

    uart_core i_uart_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mk_frame(input logic [7:0] d, input int len, input int pm,
                            input bit s2, output logic [15:0] f, output int n);
        logic p;
        f = '1;
        f[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < len; i++) begin
            f[1+i] = d[i];
            p ^= d[i];
        end
        n = 1 + len;
        if (pm == 1) begin f[n] = p;  n++; end
        else if (pm == 2) begin f[n] = ~p; n++; end
        n += s2 ? 2 : 1;
    endtask

    task automatic send_bits(input logic [15:0] f, input int n, input int bt);
        for (int i = 0; i < n; i++) begin
            rx_drv = f[i];
            wait_clk(bt);
        end
        rx_drv = 1'b1;
    endtask

    task automatic capture(input int n, input int bt, output logic [15:0] got);
        int guard;
        got = '1;
        guard = 0;
        while (txd !== 1'b0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        wait_clk(bt / 2);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            wait_clk(bt);
        end
    endtask

    task automatic soft_reset(input logic [7:0] ctrl);
        wr(3'd3, 8'h00);
        wr(3'd3, ctrl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  st, rb;
        logic [15:0] f, got;
        int          n, cnt;
        int          bt;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        // R13 reset state
        rd(3'd4, st);
        chk("R13 status after reset", st, 8'h03);
        chk("R13 line idle", txd, 1);
        chk("R13 irqs low", {tx_irq, rx_irq}, 0);

        // R6 / R12: transmit gating by tx enable
        bt = 16;
        wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        wr(3'd0, 8'h07);
        wr(3'd3, 8'h14);
        wr(3'd5, 8'hA5);
        rd(3'd4, st);
        chk("R6 tx ready cleared by write", st[0], 0);
        wait_clk(100);
        chk("R12 line high with tx disabled", txd, 1);
        chk("R6 tx irq low while buffer full", tx_irq, 0);
        wr(3'd3, 8'h15);
        mk_frame(8'hA5, 8, 0, 1'b0, f, n);
        capture(n, bt, got);
        chk("R1 frame 0xA5 8N1", got, f);
        rd(3'd4, st);
        chk("R6 tx ready after transfer", st[0], 1);
        chk("R6 tx irq", tx_irq, 1);

        // Format sweep in loopback: R1 R2 R3 R4 R7
        soft_reset(8'h1B);
        for (int len = 1; len <= 8; len++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int s2 = 0; s2 < 2; s2++) begin
                    logic [7:0] d, m;
                    d = 8'(len * 37 + pm * 11 + s2 * 5 + 8'h5A);
                    m = 8'((1 << len) - 1);
                    wr(3'd0, 8'((s2 << 5) | (pm << 3) | (len - 1)));
                    wr(3'd5, d);
                    mk_frame(d, len, (pm == 3) ? 0 : pm, s2[0], f, n);
                    capture(n, bt, got);
                    chk($sformatf("R1 R3 R4 frame len%0d par%0d stop%0d", len, pm, s2 + 1), got, f);
                    wait_clk(bt);
                    rd(3'd4, st);
                    chk("R7 rx ready, no errors", st & 8'h7C, 8'h04);
                    rd(3'd6, rb);
                    chk("R2 received char right-justified", rb, d & m);
                    rd(3'd4, st);
                    chk("R7 rx ready cleared by read", st[2], 0);
                end
            end
        end

        // R5 bit time
        wr(3'd0, 8'h07);
        wr(3'd1, 8'h00); wr(3'd2, 8'd78);
        wr(3'd5, 8'h01);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0) begin cnt++; @(negedge clk); end
        chk("R5 bit time divisor 78", cnt, (78 + 1) * 8);
        chk("R5 rate near 4800 at 3 MHz", (3000000 / cnt > 4700) && (3000000 / cnt < 4900), 1);
        wait_clk(632 * 10);
        wr(3'd1, 8'h01); wr(3'd2, 8'h00);
        wr(3'd5, 8'h01);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0) begin cnt++; @(negedge clk); end
        chk("R5 bit time divisor 0x0100", cnt, (256 + 1) * 8);
        wait_clk(2056 * 10);

        // Error injection with the bench driving the line
        loop = 1'b0;
        wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        wr(3'd0, 8'h0F);
        soft_reset(8'h1A);

        mk_frame(8'h35, 8, 1, 1'b0, f, n);
        f[9] = ~f[9];
        send_bits(f, n, bt); wait_clk(bt);
        rd(3'd4, st);
        chk("R8 parity error flagged", st & 8'h7C, 8'h0C);
        rd(3'd6, rb);
        chk("R8 char still delivered", rb, 8'h35);
        soft_reset(8'h1A);
        rd(3'd4, st);
        chk("R13 errors cleared by run=0", st, 8'h03);

        mk_frame(8'hC3, 8, 1, 1'b0, f, n);
        f[10] = 1'b0;
        send_bits(f, n, bt); wait_clk(bt);
        rd(3'd4, st);
        chk("R8 framing error flagged", st & 8'h7C, 8'h24);
        soft_reset(8'h1A);

        mk_frame(8'h11, 8, 1, 1'b0, f, n);
        send_bits(f, n, bt);
        mk_frame(8'h22, 8, 1, 1'b0, f, n);
        send_bits(f, n, bt); wait_clk(bt);
        rd(3'd4, st);
        chk("R9 overrun flagged", st & 8'h7C, 8'h14);
        rd(3'd6, rb);
        chk("R9 newer char kept", rb, 8'h22);
        soft_reset(8'h1A);

        rx_drv = 1'b0;
        wait_clk(bt * 13);
        rx_drv = 1'b1;
        wait_clk(bt * 2);
        rd(3'd4, st);
        chk("R10 break only, no char", st & 8'h7C, 8'h40);
        chk("R10 break raises rx irq", rx_irq, 1);
        soft_reset(8'h1A);

        rx_drv = 1'b0;
        wait_clk(bt / 4);
        rx_drv = 1'b1;
        wait_clk(bt * 14);
        rd(3'd4, st);
        chk("R11 glitch ignored", st & 8'h7C, 8'h00);
        mk_frame(8'h6E, 8, 1, 1'b0, f, n);
        send_bits(f, n, bt); wait_clk(bt);
        rd(3'd4, st);
        chk("R11 next frame received", st & 8'h7C, 8'h04);
        chk("R7 rx irq with char ready", rx_irq, 1);
        rd(3'd6, rb);
        chk("R11 char after glitch", rb, 8'h6E);
        chk("R7 rx irq clears on read", rx_irq, 0);

        wr(3'd3, 8'h18);
        mk_frame(8'h77, 8, 1, 1'b0, f, n);
        send_bits(f, n, bt); wait_clk(bt);
        rd(3'd4, st);
        chk("R12 frame ignored with rx disabled", st & 8'h7C, 8'h00);

        wr(3'd3, 8'h00);
        wait_clk(2);
        rd(3'd4, st);
        chk("R13 status while stopped", st, 8'h03);
        chk("R13 irqs low while stopped", {tx_irq, rx_irq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule